// File: doc/BRIEF.md
# Multioperand Decimal Adder with Folded Digit Corrections

This block sums a fixed number of unsigned packed-decimal operands, each a row of 4-bit decimal digits, in one combinational pass followed by a result register. Every digit column is its own slice. The slice runs a linear chain of 4-bit carry-save stages. In each stage, a carry bit that leaves the column weighs sixteen inside the column, but it enters the next column as a decimal carry worth ten. The missing six is not repaired inside the chain. It is folded into the next operand ahead of time: that operand's digit plus six is formed from the raw digit alone, and a 2:1 mux picks it. So the chain never has to compare and correct.

At the bottom of each column, a speculation fix covers the carries that were still uncorrected when the chain ended. The column then compresses to a small residue. A word-wide decimal resolver turns the residues into valid digits and ripples the decimal carries across the columns. Carries that leave the most significant column are either kept as extra result digits or discarded, depending on a build-time choice.

A build-time variant steers each mux with the carry from two stages back instead of one. This takes the mux off the serial path. In exchange, the final fix can be 0, 6 or 12.

Top module: `mbcd_adder`

## Requirements
- R1: With KEEP_CARRY=1 the registered result equals the exact decimal sum of all NUM_OPS operands. The result has NUM_DIGITS plus the digit count of NUM_OPS-1 digits, so a sum of all-nines operands never overflows.
- R2: With KEEP_CARRY=0 the result has NUM_DIGITS digits and equals the exact sum modulo 10^NUM_DIGITS. Carries out of the top column are dropped.
- R3: Operand k occupies bits [k*4*NUM_DIGITS +: 4*NUM_DIGITS] of `operands`. Inside an operand and inside `sum`, digit j sits at bits [4j +: 4], with the least significant digit at bit 0.
- R4: When `in_valid` is high at a clock edge, `out_valid` is high after that edge and `sum` shows the result for the operands sampled at that edge.
- R5: When `in_valid` is low at an edge, `out_valid` is low after it and `sum` keeps its previous value, whatever the operands carry.
- R6: While `rst` is high at an edge, `out_valid` and `sum` are cleared to zero after it.
- R7: Every 4-bit digit of a valid `sum` lies in 0..9.
- R8: With DOUBLE_SPEC=1 (mux steered by the carry from two stages back, final fix 0, 6 or 12) every result matches R1 and R2.
- R9: The single-column case 9+8+7+6+5 yields 35: units digit 5 with three tens carried out.
- R10: 299+398+497+596+695 yields 2485.
- R11: Five operands of 999 yield 4995 in the wide form and 995 in the narrow form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid and are summed at this edge |
| operands | input | NUM_OPS*NUM_DIGITS*4 | Packed decimal operands, operand 0 lowest |
| out_valid | output | 1 | `sum` was loaded by the previous edge |
| sum | output | OUT_DIGITS*4 | Packed decimal result |

## Verification
The bench builds three copies with five operands of three digits each:
- single-stage steering with the top carries kept;
- two-stage steering with the top carries kept;
- single-stage steering with the top carries dropped.

Five operands are enough for every column to take multiple stage carries and to reach the 0/6/12 final fix. Three digits let carries ripple through a middle column into a fourth output digit.

A sweep walks all 10,000 combinations of repeated-digit values on four operands, with a varying fifth operand. A further run uses pseudo-random operands. Both compare all three copies against integer sums.

// File: rtl/mbcd_pkg.sv
package mbcd_pkg;

    typedef logic [3:0] bcd_t;

    // one carry-save word of a digit column: sum bits and carry bits [4:0],
    // carry bit 0 arrives from the next lower column
    typedef struct packed {
        logic [3:0] s;
        logic [4:0] c;
    } csa_word_t;

    // digit plus six as flat two-level logic, valid for inputs 0..9
    function automatic bcd_t add_six(bcd_t d);
        bcd_t r;
        r[0] = d[0];
        r[1] = ~d[1];
        r[2] = ~(d[2] ^ d[1]);
        r[3] = d[3] ^ (d[2] | d[1]);
        return r;
    endfunction

    // number of decimal digits needed for a non-negative value
    function automatic int dec_width(int v);
        int w;
        int x;
        w = 1;
        x = v;
        while (x >= 10) begin
            x = x / 10;
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/mbcd_digit_slice.sv
module mbcd_digit_slice
    import mbcd_pkg::*;
#(
    parameter int NUM_OPS     = 5,
    parameter bit DOUBLE_SPEC = 1'b0,
    parameter int RES_W       = 6
) (
    input  logic [NUM_OPS*4-1:0] col,
    input  logic [NUM_OPS-1:1]   carry_in,
    output logic [NUM_OPS-1:1]   carry_out,
    output logic [RES_W-1:0]     residue
);

    localparam int LAST = NUM_OPS - 1;

    bcd_t      dig [NUM_OPS];
    csa_word_t st  [1:LAST];

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_dig
        assign dig[k] = col[k*4 +: 4];
    end

    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        if (i == 1) begin : g_first
            // two operands through four half adders
            assign st[1] = {dig[0] ^ dig[1], dig[0] & dig[1], carry_in[1]};
        end else begin : g_acc
            logic pick;
            bcd_t addend;
            logic [3:0] prev_c;
            if (DOUBLE_SPEC) begin : g_two_back
                if (i >= 3) begin : g_sel
                    assign pick = st[i-2].c[4];
                end else begin : g_none
                    assign pick = 1'b0;
                end
            end else begin : g_one_back
                assign pick = st[i-1].c[4];
            end
            assign prev_c = st[i-1].c[3:0];
            assign addend = pick ? add_six(dig[i]) : dig[i];
            assign st[i]  = {st[i-1].s ^ prev_c ^ addend,
                             (st[i-1].s & prev_c) | (st[i-1].s & addend) | (prev_c & addend),
                             carry_in[i]};
        end
        assign carry_out[i] = st[i].c[4];
    end

    // speculation fix for carries not yet compensated by a later operand
    logic [3:0] spec_fix;
    if (DOUBLE_SPEC && (NUM_OPS >= 3)) begin : g_fix_two
        always_comb begin
            case ({st[LAST-1].c[4], st[LAST].c[4]})
                2'b00:        spec_fix = 4'd0;
                2'b11:        spec_fix = 4'd12;
                default:      spec_fix = 4'd6;
            endcase
        end
    end else begin : g_fix_one
        assign spec_fix = st[LAST].c[4] ? 4'd6 : 4'd0;
    end

    assign residue = RES_W'(st[LAST].s) + RES_W'(st[LAST].c[3:0]) + RES_W'(spec_fix);

endmodule

// File: rtl/mbcd_resolve.sv
module mbcd_resolve #(
    parameter int POSITIONS = 4,
    parameter int VAL_W     = 8
) (
    input  logic [POSITIONS*VAL_W-1:0] column_val,
    output logic [POSITIONS*4-1:0]     digits
);

    localparam int TW = VAL_W + 1;
    localparam logic [TW-1:0] TEN = TW'(10);

    logic [TW-1:0] carry;
    logic [TW-1:0] total;

    // word-wide decimal ripple: each column keeps total mod 10, passes the tens on
    always_comb begin
        carry  = '0;
        total  = '0;
        digits = '0;
        for (int j = 0; j < POSITIONS; j++) begin
            total = {1'b0, column_val[j*VAL_W +: VAL_W]} + carry;
            digits[j*4 +: 4] = 4'(total % TEN);
            carry = total / TEN;
        end
    end

endmodule

// File: rtl/mbcd_adder.sv
module mbcd_adder
    import mbcd_pkg::*;
#(
    parameter int NUM_OPS     = 5,
    parameter int NUM_DIGITS  = 3,
    parameter bit DOUBLE_SPEC = 1'b0,
    parameter bit KEEP_CARRY  = 1'b1,
    localparam int OUT_DIGITS = NUM_DIGITS + (KEEP_CARRY ? dec_width(NUM_OPS - 1) : 0)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [NUM_OPS*NUM_DIGITS*4-1:0] operands,
    output logic                            out_valid,
    output logic [OUT_DIGITS*4-1:0]         sum
);

    localparam int OP_W  = NUM_DIGITS * 4;
    localparam int RES_W = 6;
    localparam int VAL_W = 8;

    logic [NUM_OPS-1:1]          ripple [0:NUM_DIGITS];
    logic [OUT_DIGITS*VAL_W-1:0] col_val;
    logic [OUT_DIGITS*4-1:0]     digits_next;

    assign ripple[0] = '0;

    for (genvar j = 0; j < NUM_DIGITS; j++) begin : g_col
        logic [NUM_OPS*4-1:0] col;
        logic [RES_W-1:0]     res;
        for (genvar k = 0; k < NUM_OPS; k++) begin : g_gather
            assign col[k*4 +: 4] = operands[k*OP_W + j*4 +: 4];
        end
        mbcd_digit_slice #(
            .NUM_OPS    (NUM_OPS),
            .DOUBLE_SPEC(DOUBLE_SPEC),
            .RES_W      (RES_W)
        ) u_slice (
            .col      (col),
            .carry_in (ripple[j]),
            .carry_out(ripple[j+1]),
            .residue  (res)
        );
        assign col_val[j*VAL_W +: VAL_W] = {{(VAL_W-RES_W){1'b0}}, res};
    end

    if (KEEP_CARRY) begin : g_keep
        logic [VAL_W-1:0] top_count;
        always_comb begin
            top_count = '0;
            for (int k = 1; k < NUM_OPS; k++) begin
                top_count = top_count + {{(VAL_W-1){1'b0}}, ripple[NUM_DIGITS][k]};
            end
        end
        assign col_val[NUM_DIGITS*VAL_W +: VAL_W] = top_count;
        for (genvar j = NUM_DIGITS + 1; j < OUT_DIGITS; j++) begin : g_pad
            assign col_val[j*VAL_W +: VAL_W] = '0;
        end
    end else begin : g_drop
        logic dropped_unused;
        assign dropped_unused = ^ripple[NUM_DIGITS];
    end

    mbcd_resolve #(
        .POSITIONS(OUT_DIGITS),
        .VAL_W    (VAL_W)
    ) u_resolve (
        .column_val(col_val),
        .digits    (digits_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sum       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum <= digits_next;
            end
        end
    end

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(sum)));

    // R1
    zero_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && operands == '0) |=> (sum == '0));

    for (genvar d = 0; d < OUT_DIGITS; d++) begin : g_range
        // R7
        digit_range_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (sum[d*4 +: 4] <= 4'd9));
    end

endmodule

// File: tb/mbcd_adder_tb.sv
module mbcd_adder_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int M  = 5;
    localparam int N  = 3;
    localparam int OW = N * 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst;
    logic            in_valid;
    logic [M*OW-1:0] ops;
    logic            ov_s, ov_d, ov_n;
    logic [15:0]     sum_s, sum_d;
    logic [11:0]     sum_n;

    int errors = 0;
    int checks = 0;
    int vals [M];

    mbcd_adder #(.NUM_OPS(M), .NUM_DIGITS(N), .DOUBLE_SPEC(1'b0), .KEEP_CARRY(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operands(ops),
        .out_valid(ov_s), .sum(sum_s));

    mbcd_adder #(.NUM_OPS(M), .NUM_DIGITS(N), .DOUBLE_SPEC(1'b1), .KEEP_CARRY(1'b1)) u_dut_dbl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operands(ops),
        .out_valid(ov_d), .sum(sum_d));

    mbcd_adder #(.NUM_OPS(M), .NUM_DIGITS(N), .DOUBLE_SPEC(1'b0), .KEEP_CARRY(1'b0)) u_dut_nar (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operands(ops),
        .out_valid(ov_n), .sum(sum_n));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int decode(logic [15:0] v, int nd, output int bad);
        int r = 0;
        int p = 1;
        bad = 0;
        for (int j = 0; j < nd; j++) begin
            if (v[j*4 +: 4] > 4'd9) bad = 1;
            r = r + int'(v[j*4 +: 4]) * p;
            p = p * 10;
        end
        return r;
    endfunction

    task automatic load_ops();
        for (int k = 0; k < M; k++) begin
            int p = 1;
            for (int j = 0; j < N; j++) begin
                ops[k*OW + j*4 +: 4] = 4'((vals[k] / p) % 10);
                p = p * 10;
            end
        end
    endtask

    task automatic run_vec(string tag);
        int total = 0;
        int bad_s, bad_d, bad_n;
        int got_s, got_d, got_n;
        for (int k = 0; k < M; k++) total += vals[k];
        load_ops();
        in_valid = 1'b1;
        @(negedge clk);
        got_s = decode(sum_s, 4, bad_s);
        got_d = decode(sum_d, 4, bad_d);
        got_n = decode({4'd0, sum_n}, 3, bad_n);
        check({tag, " R4 valid after load"}, int'(ov_s & ov_d & ov_n), 1);
        check({tag, " R7 digits in range"}, bad_s + bad_d + bad_n, 0);
        check({tag, " R1 wide sum"}, got_s, total);
        check({tag, " R8 two-back steering"}, got_d, total);
        check({tag, " R2 narrow sum"}, got_n, total % 1000);
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lcg;
        logic [15:0] held_s;
        rst = 1'b1;
        in_valid = 1'b0;
        ops = '0;
        repeat (3) @(negedge clk);
        // R6 reset state
        check("R6 reset valid", int'(ov_s | ov_d | ov_n), 0);
        check("R6 reset sum", int'(sum_s | sum_d) + int'(sum_n), 0);
        rst = 1'b0;
        @(negedge clk);

        // R9 single column example
        vals = '{9, 8, 7, 6, 5};
        run_vec("R9 column 9+8+7+6+5");
        check("R9 units digit", int'(sum_s[3:0]), 5);
        check("R9 tens carried", int'(sum_s[7:4]), 3);

        // R10 word example
        vals = '{299, 398, 497, 596, 695};
        run_vec("R10 word example");
        check("R10 result", int'(sum_s), 16'h2485);

        // R3 digit placement
        vals = '{1, 20, 300, 0, 0};
        run_vec("R3 placement");
        check("R3 packed layout", int'(sum_s), 16'h0321);

        // R11 all nines
        vals = '{999, 999, 999, 999, 999};
        run_vec("R11 all nines");
        check("R11 wide", int'(sum_s), 16'h4995);
        check("R11 narrow", int'(sum_n), 12'h995);

        // R5 hold while idle with changed operands
        held_s = sum_s;
        vals = '{123, 456, 789, 12, 345};
        load_ops();
        in_valid = 1'b0;
        @(negedge clk);
        check("R5 valid low when idle", int'(ov_s | ov_d | ov_n), 0);
        check("R5 sum held", int'(sum_s), int'(held_s));
        check("R5 narrow held", int'(sum_n), 12'h995);

        // R1 zero operands
        vals = '{0, 0, 0, 0, 0};
        run_vec("R1 zeros");

        // R1 R8 sweep of repeated-digit operands
        for (int idx = 0; idx < 10000; idx++) begin
            int p = 1;
            for (int k = 0; k < 4; k++) begin
                vals[k] = ((idx / p) % 10) * 111;
                p = p * 10;
            end
            vals[4] = (idx % 7) * 142;
            run_vec("R1 sweep");
        end

        // R1 R8 pseudo-random operands
        lcg = 12345;
        for (int t = 0; t < 4000; t++) begin
            for (int k = 0; k < M; k++) begin
                lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
                vals[k] = (lcg >> 8) % 1000;
            end
            run_vec("R1 random");
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule